// File: doc/BRIEF.md
# LCD Status Interrupt Line Generator

This block holds the display controller's status register and turns its condition sources into a single interrupt request. Its inputs are:

- the current display mode from the timing sequencer;
- the current line-compare value and a flag that says whether that value is valid;
- a marker for the cycle in which the vertical blank period begins;
- CPU writes to the status register and to the line-compare target register.

The block keeps the coincidence flag current. It merges every enabled source into one internal line. It emits a one-cycle request pulse for interrupt-flag bit 1 only when that line rises.

All sources share the one line, so a source that becomes true while another source already holds the line high produces no request. The line is evaluated combinationally on every dot-clock cycle. A CPU write that enables a source which is already true therefore raises a request in the cycle after the write edge.

In the cycle that marks vertical blank entry, the OAM-search enable is also honoured, as if mode 2 were evaluated once before mode 1 takes over. A parameter can remove this behaviour.

Top module: `lcd_stat_irq`

## Requirements
- R1: After reset, all source enables are 0, the request output is low, and the status read data is {1, 0000, coincidence flag, mode}.
- R2: The coincidence flag (status bit 2) is 1 only when the compare value is valid and equals the stored target. It is 0 whenever the values differ or the compare value is invalid.
- R3: A status write (select 0) changes only the enables in bits 6:3. Bits 2:0 keep showing the flag and the mode, bit 7 always reads 1, and the enables hold their value when no status write occurs.
- R4: The internal line is the enable for the current mode (bit 3 for mode 0, bit 4 for mode 1, bit 5 for mode 2), ORed with (bit 6 AND the coincidence flag).
- R5: The request pulse lasts one cycle and occurs only on a low-to-high change of the internal line. A line that stays high requests nothing more.
- R6: A status or target write that makes the line true raises a request in the cycle after the write edge.
- R7: A second source becoming true while the line is already high raises no request.
- R8: When the vertical blank entry marker is high and enable bit 5 is set, the line is high in that cycle, even though the mode is 1.
- R9: A target write (select 1) stores data bits LINE_W-1:0 as the new compare target.
- R10: Mode 3 contributes no source; with no coincidence source and no entry marker, the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Current display mode (0 hblank, 1 vblank, 2 OAM search, 3 transfer) |
| cmp_val_i | input | LINE_W | Current line-compare value |
| cmp_valid_i | input | 1 | Compare value is valid |
| vbl_entry_i | input | 1 | High for the cycle in which vertical blank begins |
| wr_en_i | input | 1 | CPU write strobe |
| wr_sel_i | input | 1 | Write target: 0 status, 1 compare target |
| wr_data_i | input | 8 | CPU write data |
| stat_rd_o | output | 8 | Status read data |
| irq_set_o | output | 1 | One-cycle request to set interrupt-flag bit 1 |

## Verification
The assertions check the following on every cycle:

- every request is a single-cycle pulse made while the line is high;
- an invalid compare value never shows a coincidence;
- the enables never move without a write;
- mode 3 with no other source never requests;
- the vertical blank entry with the OAM-search enable set always requests from a low line.

Some behaviour shows only across ordered stimulus, so only the bench's scenarios can demonstrate it. This covers overlap suppression between sources, requests caused by the writes themselves, the target comparison, and the mode-by-mode walk through the enables.

// File: rtl/lcd_stat_pkg.sv
package lcd_stat_pkg;

   // Display mode codes as seen in status bits 1:0
   localparam logic [1:0] MODE_HBL  = 2'd0;
   localparam logic [1:0] MODE_VBL  = 2'd1;
   localparam logic [1:0] MODE_OAM  = 2'd2;
   localparam logic [1:0] MODE_XFER = 2'd3;

   // Write select codes
   localparam logic SEL_STAT = 1'b0;
   localparam logic SEL_LYC  = 1'b1;

   // Source enables, packed in the order of status bits 6:3
   typedef struct packed {
      logic coin;
      logic oam;
      logic vbl;
      logic hbl;
   } src_en_t;

   localparam int EN_LSB = 3;
   localparam int EN_W   = $bits(src_en_t);

endpackage

// File: rtl/lcd_stat_regs.sv
module lcd_stat_regs
   import lcd_stat_pkg::*;
#(
   parameter int LINE_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output src_en_t           src_en_o,
   output logic [LINE_W-1:0] lyc_o
);

   localparam int EN_MSB = EN_LSB + EN_W - 1;

   src_en_t           en_q;
   logic [LINE_W-1:0] lyc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         lyc_q <= '0;
      end else if (wr_en_i) begin
         if (wr_sel_i == SEL_STAT) en_q  <= src_en_t'(wr_data_i[EN_MSB:EN_LSB]);
         else                      lyc_q <= wr_data_i[LINE_W-1:0];
      end
   end

   assign src_en_o = en_q;
   assign lyc_o    = lyc_q;

endmodule

// File: rtl/lcd_stat_match.sv
module lcd_stat_match #(
   parameter int LINE_W = 8
) (
   input  logic [LINE_W-1:0] cmp_val_i,
   input  logic              cmp_valid_i,
   input  logic [LINE_W-1:0] lyc_i,
   output logic              coin_o
);

   assign coin_o = cmp_valid_i && (cmp_val_i == lyc_i);

endmodule

// File: rtl/lcd_stat_line.sv
module lcd_stat_line
   import lcd_stat_pkg::*;
#(
   parameter bit VBL_OAM_FIRE = 1'b1
) (
   input  logic [1:0] mode_i,
   input  src_en_t    src_en_i,
   input  logic       coin_i,
   input  logic       vbl_entry_i,
   output logic       line_o
);

   logic mode_src;
   logic entry_src;

   always_comb begin
      unique case (mode_i)
         MODE_HBL: mode_src = src_en_i.hbl;
         MODE_VBL: mode_src = src_en_i.vbl;
         MODE_OAM: mode_src = src_en_i.oam;
         default:  mode_src = 1'b0;
      endcase
   end

   generate
      if (VBL_OAM_FIRE) begin : g_entry_fire
         assign entry_src = vbl_entry_i & src_en_i.oam;
      end else begin : g_entry_none
         logic unused_entry;
         assign unused_entry = vbl_entry_i;
         assign entry_src    = 1'b0;
      end
   endgenerate

   assign line_o = mode_src | entry_src | (src_en_i.coin & coin_i);

endmodule

// File: rtl/lcd_stat_irq.sv
module lcd_stat_irq
   import lcd_stat_pkg::*;
#(
   parameter int LINE_W       = 8,
   parameter bit VBL_OAM_FIRE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [LINE_W-1:0] cmp_val_i,
   input  logic              cmp_valid_i,
   input  logic              vbl_entry_i,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [7:0]        wr_data_i,
   output logic [7:0]        stat_rd_o,
   output logic              irq_set_o
);

   localparam int DATA_W = 8;

   initial begin
      if (LINE_W < 1 || LINE_W > DATA_W)
         $error("lcd_stat_irq: LINE_W must lie in 1..%0d", DATA_W);
   end

   src_en_t           src_en;
   logic [LINE_W-1:0] lyc;
   logic              coin;
   logic              line_w;
   logic              line_q;

   lcd_stat_regs #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .src_en_o  (src_en),
      .lyc_o     (lyc)
   );

   lcd_stat_match #(.LINE_W(LINE_W)) u_match (
      .cmp_val_i   (cmp_val_i),
      .cmp_valid_i (cmp_valid_i),
      .lyc_i       (lyc),
      .coin_o      (coin)
   );

   lcd_stat_line #(.VBL_OAM_FIRE(VBL_OAM_FIRE)) u_line (
      .mode_i      (mode_i),
      .src_en_i    (src_en),
      .coin_i      (coin),
      .vbl_entry_i (vbl_entry_i),
      .line_o      (line_w)
   );

   // Previous value of the shared line; edge detection
   always_ff @(posedge clk) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= line_w;
   end

   assign irq_set_o = line_w & ~line_q;
   assign stat_rd_o = {1'b1, src_en, coin, mode_i};

endmodule

// File: rtl/lcd_stat_irq_chk.sv
module lcd_stat_irq_chk #(
   parameter bit VBL_OAM_FIRE = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_i,
   input logic       cmp_valid_i,
   input logic       vbl_entry_i,
   input logic       wr_en_i,
   input logic [7:0] stat_rd_o,
   input logic       irq_set_o,
   input logic       line_w,
   input logic       line_q
);

   // R5
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set_o |=> !irq_set_o);

   // R5
   rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set_o |-> (line_w && !line_q));

   // R2
   invalid_no_coin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid_i |-> !stat_rd_o[2]);

   // R3
   enables_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(stat_rd_o[6:3]));

   // R10
   xfer_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd3 && !vbl_entry_i && !(stat_rd_o[6] && stat_rd_o[2])) |-> !irq_set_o);

   // R8
   vbl_entry_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (VBL_OAM_FIRE && vbl_entry_i && stat_rd_o[5] && !line_q) |-> irq_set_o);

endmodule

bind lcd_stat_irq lcd_stat_irq_chk #(.VBL_OAM_FIRE(VBL_OAM_FIRE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode_i      (mode_i),
   .cmp_valid_i (cmp_valid_i),
   .vbl_entry_i (vbl_entry_i),
   .wr_en_i     (wr_en_i),
   .stat_rd_o   (stat_rd_o),
   .irq_set_o   (irq_set_o),
   .line_w      (line_w),
   .line_q      (line_q)
);

// File: tb/lcd_stat_irq_bench.sv
module lcd_stat_irq_bench;

   localparam int CLK_P  = 10;
   localparam int LINE_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode_i = 2'd0;
   logic [LINE_W-1:0] cmp_val_i = '0;
   logic              cmp_valid_i = 1'b0;
   logic              vbl_entry_i = 1'b0;
   logic              wr_en_i = 1'b0;
   logic              wr_sel_i = 1'b0;
   logic [7:0]        wr_data_i = '0;
   logic [7:0]        stat_rd_o;
   logic              irq_set_o;

   int n_chk = 0;
   int n_bad = 0;

   lcd_stat_irq #(.LINE_W(LINE_W), .VBL_OAM_FIRE(1'b1)) u_lcd_stat_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (mode_i),
      .cmp_val_i   (cmp_val_i),
      .cmp_valid_i (cmp_valid_i),
      .vbl_entry_i (vbl_entry_i),
      .wr_en_i     (wr_en_i),
      .wr_sel_i    (wr_sel_i),
      .wr_data_i   (wr_data_i),
      .stat_rd_o   (stat_rd_o),
      .irq_set_o   (irq_set_o)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // Write on one edge; sample a quarter period after it
   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
      @(posedge clk);
      #(CLK_P/4);
      wr_en_i = 1'b0;
   endtask

   // Change inputs at a falling edge; sample a quarter period later
   task automatic drv(input logic [1:0] m, input logic [7:0] c, input logic v, input logic e);
      @(negedge clk);
      mode_i = m; cmp_val_i = c; cmp_valid_i = v; vbl_entry_i = e;
      #(CLK_P/4);
   endtask

   task automatic next_cycle();
      @(posedge clk);
      #(CLK_P/4);
   endtask

   // Quiet state: line low, no sources
   task automatic quiesce();
      drv(2'd3, 8'd0, 1'b0, 1'b0);
      wr(1'b0, 8'h00);
      next_cycle();
   endtask

   task automatic t_reset();
      chk("R1 reset status", stat_rd_o, 8'h80);
      chk("R1 reset request", {7'd0, irq_set_o}, 8'h00);
   endtask

   task automatic t_write_raises();
      quiesce();
      drv(2'd2, 8'd0, 1'b0, 1'b0);
      chk("R10/R4 mode2 no enable", {7'd0, irq_set_o}, 8'h00);
      wr(1'b0, 8'hFF);
      chk("R3 status after write ff", stat_rd_o, 8'hFA);
      chk("R6 write raises request", {7'd0, irq_set_o}, 8'h01);
      next_cycle();
      chk("R5 pulse one cycle", {7'd0, irq_set_o}, 8'h00);
   endtask

   task automatic t_ro_bits();
      quiesce();
      drv(2'd1, 8'd0, 1'b0, 1'b0);
      wr(1'b0, 8'h07);
      chk("R3 low bits read only", stat_rd_o, 8'h81);
   endtask

   task automatic t_coin();
      quiesce();
      wr(1'b1, 8'd5);
      drv(2'd3, 8'd5, 1'b1, 1'b0);
      chk("R2 R9 match sets flag", {7'd0, stat_rd_o[2]}, 8'h01);
      drv(2'd3, 8'd6, 1'b1, 1'b0);
      chk("R2 mismatch clears flag", {7'd0, stat_rd_o[2]}, 8'h00);
      drv(2'd3, 8'd5, 1'b0, 1'b0);
      chk("R2 invalid clears flag", {7'd0, stat_rd_o[2]}, 8'h00);
   endtask

   task automatic t_coin_irq();
      quiesce();
      wr(1'b1, 8'd7);
      drv(2'd3, 8'd6, 1'b1, 1'b0);
      wr(1'b0, 8'h40);
      chk("R4 coincidence off no request", {7'd0, irq_set_o}, 8'h00);
      drv(2'd3, 8'd7, 1'b1, 1'b0);
      chk("R4 coincidence request", {7'd0, irq_set_o}, 8'h01);
      next_cycle();
      chk("R5 held line no request", {7'd0, irq_set_o}, 8'h00);
   endtask

   task automatic t_overlap();
      quiesce();
      wr(1'b1, 8'd9);
      drv(2'd0, 8'd8, 1'b1, 1'b0);
      wr(1'b0, 8'h48);
      next_cycle();
      drv(2'd0, 8'd9, 1'b1, 1'b0);
      chk("R7 overlap flag set", {7'd0, stat_rd_o[2]}, 8'h01);
      chk("R7 overlap suppressed", {7'd0, irq_set_o}, 8'h00);
   endtask

   task automatic t_modes();
      quiesce();
      wr(1'b0, 8'h38);
      next_cycle();
      chk("R10 mode3 silent", {7'd0, irq_set_o}, 8'h00);
      drv(2'd0, 8'd0, 1'b0, 1'b0);
      chk("R4 hblank request", {7'd0, irq_set_o}, 8'h01);
      drv(2'd1, 8'd0, 1'b0, 1'b0);
      chk("R7 hblank to vblank no request", {7'd0, irq_set_o}, 8'h00);
      drv(2'd2, 8'd0, 1'b0, 1'b0);
      chk("R7 vblank to oam no request", {7'd0, irq_set_o}, 8'h00);
      drv(2'd3, 8'd0, 1'b0, 1'b0);
      next_cycle();
      drv(2'd2, 8'd0, 1'b0, 1'b0);
      chk("R4 oam request after mode3", {7'd0, irq_set_o}, 8'h01);
   endtask

   task automatic t_vbl_entry();
      quiesce();
      drv(2'd0, 8'd0, 1'b0, 1'b0);
      wr(1'b0, 8'h20);
      next_cycle();
      drv(2'd1, 8'd0, 1'b0, 1'b1);
      chk("R8 entry with oam enable", {7'd0, irq_set_o}, 8'h01);
      drv(2'd1, 8'd0, 1'b0, 1'b0);
      next_cycle();
      drv(2'd0, 8'd0, 1'b0, 1'b0);
      wr(1'b0, 8'h00);
      next_cycle();
      drv(2'd1, 8'd0, 1'b0, 1'b1);
      chk("R8 entry without enable", {7'd0, irq_set_o}, 8'h00);
      drv(2'd1, 8'd0, 1'b0, 1'b0);
   endtask

   initial begin
      #(CLK_P * 5000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #(CLK_P/4);
      t_reset();
      t_write_raises();
      t_ro_bits();
      t_coin();
      t_coin_irq();
      t_overlap();
      t_modes();
      t_vbl_entry();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule